// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block keeps a free-running 32-bit tick counter and a 32-bit threshold register. When an enabled tick carries the counter onto the threshold value, a timer interrupt becomes pending. It stays pending until software writes the threshold again. The pending interrupt drives exactly one of eight interrupt lines, and a 3-bit routing input picks that line. A freeze input stops the counter and blocks new interrupts.

Software writes either register through a single write port. An optional status flag follows the interrupt, but only while the 3-bit revision input equals 1. The tick input is an enable that the surrounding clocking logic pulses at the nominal counting rate.

Top module: `cmp_timer`

## Requirements
- R1: After reset, count_o is 1, compare_o is 0, irq_o is all zeros and ti_o is 0.
- R2: When tick_i is 1, freeze_i is 0 and no count write happens, count_o rises by one at the next edge. Without tick_i it holds its value.
- R3: While freeze_i is 1, count_o holds its value and no new interrupt becomes pending, even when ticks arrive.
- R4: A write with wr_en_i=1 and wr_sel_i=0 loads wr_data_i into count_o at the next edge, and counting continues from that value. A count write that lands on the compare value does not raise the interrupt.
- R5: A write with wr_en_i=1 and wr_sel_i=1 loads wr_data_i into compare_o and clears the pending interrupt at the next edge. It takes priority over a match in the same cycle.
- R6: A tick that moves count onto compare makes the interrupt pending at that same edge. The interrupt stays pending until compare is written, and further matches while it is pending change nothing.
- R7: While the interrupt is pending, irq_o has only bit line_sel_i set. Otherwise irq_o is zero. A change of line_sel_i moves the asserted bit at the next edge.
- R8: When rev_i equals 1, a match sets ti_o and a compare write clears it. For any other rev_i value, ti_o is left unchanged.
- R9: Count wraps from 0xFFFFFFFF to 0 with no flag, and a compare value of 0 matches on that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable pulse |
| freeze_i | input | 1 | Freezes the counter and blocks new matches |
| rev_i | input | 3 | Revision field; value 1 enables ti_o |
| line_sel_i | input | 3 | Interrupt line select |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects count, 1 selects compare |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Current count |
| compare_o | output | 32 | Current compare value |
| ti_o | output | 1 | Timer interrupt status flag |
| irq_o | output | 8 | Routed interrupt lines |

## Verification
The hardest condition to reach is a match, because from a random start the counter would need billions of ticks to land on a random threshold. The stimulus therefore writes compare to a value a few ticks ahead of the current count, or writes count just below compare. Many of these writes happen while freeze_i or a pending interrupt is active, and some coincide with a match. A directed sequence loads 0xFFFFFFFF with compare at 0 to exercise the wrap match.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam logic       SEL_COUNT   = 1'b0;
  localparam logic       SEL_COMPARE = 1'b1;
  localparam logic [2:0] TI_REV      = 3'd1;
endpackage

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         freeze_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] next_o,
  output logic         step_o
);
  logic [W-1:0] cnt_q;

  assign step_o  = tick_i && !freeze_i && !ld_i;
  assign next_o  = cnt_q + 1'b1;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (ld_i)   cnt_q <= ld_data_i;
    else if (step_o) cnt_q <= next_o;
  end

  // R3
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && (freeze_i || !tick_i)) |=> cnt_q == $past(cnt_q));
  // R2
  count_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && tick_i && !freeze_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R4
  count_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_data_i));
endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         step_i,
  input  logic [W-1:0] next_i,
  input  logic         ti_en_i,
  output logic [W-1:0] compare_o,
  output logic         pend_d_o,
  output logic         pend_o,
  output logic         ti_o
);
  logic [W-1:0] cmp_q;
  logic         pend_q, ti_q, hit;

  // match only on an enabled increment; compare write wins
  assign hit      = step_i && (next_i == cmp_q) && !cmp_wr_i;
  assign pend_d_o = !cmp_wr_i && (pend_q || hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      pend_q <= 1'b0;
      ti_q   <= 1'b0;
    end else begin
      if (cmp_wr_i) cmp_q <= wr_data_i;
      pend_q <= pend_d_o;
      if (ti_en_i && cmp_wr_i) ti_q <= 1'b0;
      else if (ti_en_i && hit) ti_q <= 1'b1;
    end
  end

  assign compare_o = cmp_q;
  assign pend_o    = pend_q;
  assign ti_o      = ti_q;

  // R5
  cmp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_wr_i |=> !pend_q && cmp_q == $past(wr_data_i));
  // R6
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cmp_wr_i) |=> pend_q);
  // R8
  ti_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr_i && ti_en_i) |=> !ti_q);
  // R8
  ti_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ti_en_i |=> ti_q == $past(ti_q));
endmodule

// File: rtl/cmp_timer_route.sv
module cmp_timer_route #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pend_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[g] <= 1'b0;
      else         irq_o[g] <= pend_i && (sel_i == SEL_W'(g));
    end
  end

  // R7
  irq_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  // R7
  irq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |=> irq_o[$past(sel_i)]);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned REV_W = 3,
  localparam int unsigned N_LINES = 1 << SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               freeze_i,
  input  logic [REV_W-1:0]   rev_i,
  input  logic [SEL_W-1:0]   line_sel_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   compare_o,
  output logic               ti_o,
  output logic [N_LINES-1:0] irq_o
);
  import cmp_timer_pkg::*;

  logic             cnt_wr, cmp_wr, step, pend_d, pend_q;
  logic [CNT_W-1:0] next_cnt;

  assign cnt_wr = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign cmp_wr = wr_en_i && (wr_sel_i == SEL_COMPARE);

  cmp_timer_count #(.W(CNT_W), .RST_VAL(CNT_W'(1))) u_count (
    .clk_i, .rst_ni, .tick_i, .freeze_i,
    .ld_i(cnt_wr), .ld_data_i(wr_data_i),
    .count_o, .next_o(next_cnt), .step_o(step)
  );

  cmp_timer_match #(.W(CNT_W)) u_match (
    .clk_i, .rst_ni, .cmp_wr_i(cmp_wr), .wr_data_i,
    .step_i(step), .next_i(next_cnt),
    .ti_en_i(rev_i == REV_W'(TI_REV)),
    .compare_o, .pend_d_o(pend_d), .pend_o(pend_q), .ti_o
  );

  cmp_timer_route #(.SEL_W(SEL_W)) u_route (
    .clk_i, .rst_ni, .pend_i(pend_d), .sel_i(line_sel_i), .irq_o
  );

  // R3
  freeze_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !pend_q) |=> !pend_q);
  // R4
  load_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && !pend_q) |=> !pend_q);
endmodule

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 0, freeze = 0, wr_en = 0, wr_sel = 0;
  logic [2:0]  rev = 0, sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] count, compare;
  logic        ti;
  logic [7:0]  irq;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_cnt, m_cmp;
  logic        m_pend, m_ti;
  logic [7:0]  m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freeze_i(freeze),
    .rev_i(rev), .line_sel_i(sel), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .count_o(count), .compare_o(compare),
    .ti_o(ti), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] route(logic p, logic [2:0] s);
    return p ? (8'd1 << s) : 8'd0;
  endfunction

  task automatic model_step();
    logic cw, kw, step, hit;
    kw   = wr_en && !wr_sel;
    cw   = wr_en && wr_sel;
    step = tick && !freeze && !kw;
    hit  = step && (m_cnt + 32'd1 == m_cmp) && !cw;
    if (rev == 3'd1) begin
      if (cw) m_ti = 1'b0;
      else if (hit) m_ti = 1'b1;
    end
    m_pend = !cw && (m_pend || hit);
    m_irq  = route(m_pend, sel);
    if (kw) m_cnt = wr_data;
    else if (step) m_cnt = m_cnt + 32'd1;
    if (cw) m_cmp = wr_data;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 count", count, m_cnt);
    chk("R5 compare", compare, m_cmp);
    chk("R7 irq", {24'd0, irq}, {24'd0, m_irq});
    chk("R8 ti", {31'd0, ti}, {31'd0, m_ti});
    wr_en = 0;
  endtask

  task automatic wr(logic s, logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    cyc();
  endtask

  task automatic ticks(int n);
    tick = 1;
    for (int i = 0; i < n; i++) cyc();
    tick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_cnt = 32'd1; m_cmp = 0; m_pend = 0; m_ti = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 32'd1);
    chk("R1 compare", compare, 32'd0);
    chk("R1 irq", {24'd0, irq}, 32'd0);
    chk("R1 ti", {31'd0, ti}, 32'd0);
    // R2 plain counting
    ticks(3);
    chk("R2 after 3 ticks", count, 32'd4);
    cyc();
    chk("R2 hold without tick", count, 32'd4);
    // R6 match with routing to line 5, R8 flag
    rev = 3'd1; sel = 3'd5;
    wr(1'b1, 32'd10);
    ticks(5);
    chk("R6 no irq before match", {24'd0, irq}, 32'd0);
    ticks(1);
    chk("R6 irq at match", {24'd0, irq}, 32'h20);
    chk("R8 ti set on match", {31'd0, ti}, 32'd1);
    ticks(4);
    chk("R6 irq held", {24'd0, irq}, 32'h20);
    // R7 reroute while pending
    sel = 3'd2;
    cyc();
    chk("R7 moved line", {24'd0, irq}, 32'h04);
    // R5 compare write clears
    wr(1'b1, 32'd100);
    chk("R5 irq cleared", {24'd0, irq}, 32'd0);
    chk("R8 ti cleared", {31'd0, ti}, 32'd0);
    // R3 freeze
    wr(1'b0, 32'd98);
    freeze = 1;
    ticks(5);
    chk("R3 frozen count", count, 32'd98);
    chk("R3 no irq frozen", {24'd0, irq}, 32'd0);
    freeze = 0;
    // R4 count write onto compare
    wr(1'b0, 32'd100);
    chk("R4 no irq on load", {24'd0, irq}, 32'd0);
    ticks(1);
    chk("R4 counts from load", count, 32'd101);
    // R9 wrap with compare 0, rev 0 leaves ti
    rev = 3'd0; sel = 3'd7;
    wr(1'b1, 32'd0);
    wr(1'b0, 32'hFFFF_FFFF);
    ticks(1);
    chk("R9 wrapped", count, 32'd0);
    chk("R9 irq on wrap", {24'd0, irq}, 32'h80);
    chk("R8 ti untouched rev0", {31'd0, ti}, 32'd0);
    // R5 compare write beats same-cycle match
    rev = 3'd1;
    wr(1'b1, 32'd5);
    wr(1'b0, 32'd3);
    tick = 1;
    cyc();
    wr_en = 1; wr_sel = 1; wr_data = 32'd50;
    cyc();
    tick = 0;
    chk("R5 priority over match", {24'd0, irq}, 32'd0);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tick   = ($urandom_range(0, 9) != 0);
      freeze = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 19) == 0) rev = 3'($urandom_range(0, 2));
      if ($urandom_range(0, 15) == 0) sel = 3'($urandom);
      if (r < 4) begin
        wr_en = 1; wr_sel = 1; wr_data = m_cnt + 32'($urandom_range(0, 6));
      end else if (r < 7) begin
        wr_en = 1; wr_sel = 0; wr_data = m_cmp - 32'($urandom_range(0, 6));
      end else if (r < 8) begin
        wr_en = 1; wr_sel = 1'($urandom); wr_data = $urandom;
      end
      cyc();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule